// File: doc/BRIEF.md
# Type-Tag Range Check Unit

This unit decides in hardware whether a downcast request is legal. Each request carries the type-table pointer read from an object, the table base address of the type being cast to, a precomputed byte span covering that type and all of its descendants, and the bounds of the protected table region. A single unsigned subtraction of the base from the pointer, compared against the span, decides the primary outcome. A pointer below the base wraps to a large value and fails. A span of zero accepts only the exact base.

When the primary test fails, the unit checks whether the pointer lies inside the protected region. The usable part of the region starts one header pad above the region start and ends at the region end, inclusive. A pointer outside that window belongs to code the tables do not cover, so the request fails open. A pointer inside it is a true violation, and the unit raises a one-cycle strobe on the action output picked by the request's mode code. The do-nothing mode skips the region test altogether.

Requests use a valid/ready handshake and may arrive every cycle. Each accepted request yields exactly one result pulse two clock edges later.

Top module: `tagcast_check_unit`

## Requirements
- R1: When (obj_ptr - tgt_base) taken modulo 2^PTR_W is less than or equal to range_bytes, the result is pass (rsp_result = 2'b00) and no action strobe fires.
- R2: An obj_ptr below tgt_base fails the primary test, because the unsigned difference wraps.
- R3: With range_bytes = 0, only obj_ptr equal to tgt_base passes the primary test.
- R4: After a primary failure in modes 1, 2 or 3, an obj_ptr outside the window [region_start + PAD, region_end] is reported as fail-open (rsp_result = 2'b01) with no strobe. PAD is 16*PTR_W/8 bytes.
- R5: After a primary failure with obj_ptr inside the window, the result is violation (rsp_result = 2'b10). Mode 1 pulses fastfail_o and mode 2 pulses dbgbrk_o, each for the single cycle of rsp_valid.
- R6: In mode 3, a violation pulses handler_o only when handler_cfg is non-zero. Otherwise it reports a violation with no strobe.
- R7: Mode 4, and any code other than 1 to 4, skips the region test and reports every primary failure as a violation with no strobe.
- R8: A null obj_ptr reports pass, whatever the other inputs are.
- R9: req_ready is low during reset and high afterwards. A request accepted at one rising edge gives a one-cycle rsp_valid that becomes visible after the second following edge. Back-to-back requests each get their own result.
- R10: At most one action strobe is high in any cycle, and none fires outside rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| obj_ptr | input | PTR_W | Type-table pointer of the object being cast |
| tgt_base | input | PTR_W | Table address of the target type |
| range_bytes | input | PTR_W | Byte span of the target type and its descendants |
| region_start | input | PTR_W | Start of the protected region, aligned to PAD |
| region_end | input | PTR_W | End of the protected region |
| mode | input | 3 | Failure action: 1 fast-fail, 2 debug break, 3 handler, 4 nothing |
| handler_cfg | input | PTR_W | Handler setting; non-zero enables mode 3 |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_result | output | 2 | 00 pass, 01 fail-open, 10 violation |
| fastfail_o | output | 1 | Fast-fail strobe |
| dbgbrk_o | output | 1 | Debug-break strobe |
| handler_o | output | 1 | External-handler strobe |

## Verification
The bench builds the unit with PTR_W = 16. That makes PAD 32 bytes and keeps every pointer small enough to sweep. Object pointers from 0 to 255 are swept against two target bases, spans of 0 and 16, all eight mode codes and both zero and non-zero handler settings. This covers base wrap-around, the exact-match case, both edges of the region window, the null pointer and the unused mode codes. Expected results come from a direct arithmetic model of the requirements. A separate back-to-back sequence checks the pulse width and the pipeline spacing.

// File: rtl/tagcast_pkg.sv
package tagcast_pkg;

   typedef enum logic [1:0] {
      RES_PASS     = 2'b00,
      RES_FAILOPEN = 2'b01,
      RES_VIOL     = 2'b10
   } tc_result_e;

   typedef enum logic [2:0] {
      ACT_FASTFAIL = 3'd1,
      ACT_DBGBRK   = 3'd2,
      ACT_HANDLER  = 3'd3,
      ACT_NOTHING  = 3'd4
   } tc_mode_e;

   localparam int unsigned N_ACTIONS = 3;

   // true when the mode asks for the region test and an action strobe
   function automatic logic mode_acts(input logic [2:0] m);
      return (m == ACT_FASTFAIL) || (m == ACT_DBGBRK) || (m == ACT_HANDLER);
   endfunction

endpackage

// File: rtl/tagcast_span_cmp.sv
// Unsigned window test: hit when (ptr - base) mod 2^W <= span.
module tagcast_span_cmp #(
   parameter int unsigned W = 64
) (
   input  logic [W-1:0] ptr,
   input  logic [W-1:0] base,
   input  logic [W-1:0] span,
   output logic         hit
);
   logic [W-1:0] diff;

   always_comb begin
      diff = ptr - base;
      hit  = (diff <= span);
   end
endmodule

// File: rtl/tagcast_action_dec.sv
// Turns a confirmed violation into one strobe chosen by the mode code.
module tagcast_action_dec
   import tagcast_pkg::*;
#(
   parameter int unsigned NACT = N_ACTIONS
) (
   input  logic            fire,
   input  logic [2:0]      mode,
   input  logic            handler_en,
   output logic [NACT-1:0] strobe
);
   for (genvar i = 0; i < NACT; i++) begin : g_act
      localparam logic [2:0] CODE = 3'(i + 1);
      if (CODE == ACT_HANDLER) begin : g_gated
         assign strobe[i] = fire && (mode == CODE) && handler_en;
      end else begin : g_plain
         assign strobe[i] = fire && (mode == CODE);
      end
   end
endmodule

// File: rtl/tagcast_check_unit.sv
module tagcast_check_unit
   import tagcast_pkg::*;
#(
   parameter int unsigned PTR_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [PTR_W-1:0] obj_ptr,
   input  logic [PTR_W-1:0] tgt_base,
   input  logic [PTR_W-1:0] range_bytes,
   input  logic [PTR_W-1:0] region_start,
   input  logic [PTR_W-1:0] region_end,
   input  logic [2:0]       mode,
   input  logic [PTR_W-1:0] handler_cfg,
   output logic             rsp_valid,
   output logic [1:0]       rsp_result,
   output logic             fastfail_o,
   output logic             dbgbrk_o,
   output logic             handler_o
);
   localparam int unsigned PTR_BYTES = PTR_W / 8;
   localparam logic [PTR_W-1:0] HDR_PAD = PTR_W'(16 * PTR_BYTES);

   if ((PTR_W % 8) != 0 || PTR_W < 16) begin : g_bad_width
      $error("tagcast_check_unit: PTR_W must be a multiple of 8 and at least 16");
   end

   // ---------------- stage 1: primary test, capture ----------------
   logic             accept;
   logic             prim_hit;
   logic             s1_valid;
   logic             s1_pass;
   logic [PTR_W-1:0] s1_ptr;
   logic [PTR_W-1:0] s1_win_lo;
   logic [PTR_W-1:0] s1_win_span;
   logic [2:0]       s1_mode;
   logic             s1_hnz;

   assign accept = req_valid && req_ready;

   tagcast_span_cmp #(.W(PTR_W)) u_prim (
      .ptr  (obj_ptr),
      .base (tgt_base),
      .span (range_bytes),
      .hit  (prim_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_ready   <= 1'b0;
         s1_valid    <= 1'b0;
         s1_pass     <= 1'b0;
         s1_ptr      <= '0;
         s1_win_lo   <= '0;
         s1_win_span <= '0;
         s1_mode     <= '0;
         s1_hnz      <= 1'b0;
      end else begin
         req_ready <= 1'b1;
         s1_valid  <= accept;
         if (accept) begin
            s1_pass     <= prim_hit || (obj_ptr == '0);
            s1_ptr      <= obj_ptr;
            s1_win_lo   <= region_start + HDR_PAD;
            s1_win_span <= region_end - (region_start + HDR_PAD);
            s1_mode     <= mode;
            s1_hnz      <= (handler_cfg != '0);
         end
      end
   end

   // ---------------- stage 2: region test, action ----------------
   logic                 region_hit;
   logic                 viol_fire;
   logic [1:0]           res_d;
   logic [N_ACTIONS-1:0] strobe_d;
   logic [N_ACTIONS-1:0] strobe_q;

   tagcast_span_cmp #(.W(PTR_W)) u_region (
      .ptr  (s1_ptr),
      .base (s1_win_lo),
      .span (s1_win_span),
      .hit  (region_hit)
   );

   always_comb begin
      viol_fire = 1'b0;
      if (s1_pass) begin
         res_d = RES_PASS;
      end else if (!mode_acts(s1_mode)) begin
         res_d = RES_VIOL;
      end else if (!region_hit) begin
         res_d = RES_FAILOPEN;
      end else begin
         res_d     = RES_VIOL;
         viol_fire = s1_valid;
      end
   end

   tagcast_action_dec #(.NACT(N_ACTIONS)) u_act (
      .fire       (viol_fire),
      .mode       (s1_mode),
      .handler_en (s1_hnz),
      .strobe     (strobe_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_result <= RES_PASS;
         strobe_q   <= '0;
      end else begin
         rsp_valid <= s1_valid;
         strobe_q  <= strobe_d;
         if (s1_valid) rsp_result <= res_d;
      end
   end

   assign fastfail_o = strobe_q[0];
   assign dbgbrk_o   = strobe_q[1];
   assign handler_o  = strobe_q[2];

endmodule

// File: rtl/tagcast_check_unit_chk.sv
module tagcast_check_unit_chk #(
   parameter int unsigned PTR_W = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic [PTR_W-1:0] obj_ptr,
   input logic [2:0]       mode,
   input logic [PTR_W-1:0] handler_cfg,
   input logic             rsp_valid,
   input logic [1:0]       rsp_result,
   input logic             fastfail_o,
   input logic             dbgbrk_o,
   input logic             handler_o
);
   // R10
   strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fastfail_o, dbgbrk_o, handler_o}));

   // R10
   strobe_in_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fastfail_o || dbgbrk_o || handler_o) |-> (rsp_valid && rsp_result == 2'b10));

   // R9
   rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |-> ##2 rsp_valid);

   // R8
   null_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && obj_ptr == '0) |-> ##2 (rsp_result == 2'b00));

   // R6
   handler_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && mode == 3'd3 && handler_cfg == '0) |-> ##2 !handler_o);

   // R7
   nothing_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && mode == 3'd4) |-> ##2 !(fastfail_o || dbgbrk_o || handler_o));
endmodule

bind tagcast_check_unit tagcast_check_unit_chk #(.PTR_W(PTR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .obj_ptr     (obj_ptr),
   .mode        (mode),
   .handler_cfg (handler_cfg),
   .rsp_valid   (rsp_valid),
   .rsp_result  (rsp_result),
   .fastfail_o  (fastfail_o),
   .dbgbrk_o    (dbgbrk_o),
   .handler_o   (handler_o)
);

// File: tb/sim_tagcast_check_unit.sv
module sim_tagcast_check_unit;
   localparam int unsigned W   = 16;
   localparam logic [W-1:0] PAD = W'(16 * (W / 8));

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic         req_ready;
   logic [W-1:0] obj_ptr = '0, tgt_base = '0, range_bytes = '0;
   logic [W-1:0] region_start = '0, region_end = '0, handler_cfg = '0;
   logic [2:0]   mode = '0;
   logic         rsp_valid;
   logic [1:0]   rsp_result;
   logic         fastfail_o, dbgbrk_o, handler_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   tagcast_check_unit #(.PTR_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .obj_ptr(obj_ptr), .tgt_base(tgt_base), .range_bytes(range_bytes),
      .region_start(region_start), .region_end(region_end), .mode(mode),
      .handler_cfg(handler_cfg), .rsp_valid(rsp_valid), .rsp_result(rsp_result),
      .fastfail_o(fastfail_o), .dbgbrk_o(dbgbrk_o), .handler_o(handler_o)
   );

   task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b (ptr=%0d base=%0d rng=%0d mode=%0d hcfg=%0d)",
                  tag, act, exp, obj_ptr, tgt_base, range_bytes, mode, handler_cfg);
      end
   endtask

   // model: {valid, result, fastfail, dbgbrk, handler}
   function automatic logic [5:0] model(input logic [W-1:0] p, b, r, rs, re,
                                        input logic [2:0] m, input logic [W-1:0] h,
                                        output string tag);
      logic [W-1:0] lo;
      logic prim, inreg;
      lo    = rs + PAD;
      prim  = (W'(p - b) <= r);
      inreg = (W'(p - lo) <= W'(re - lo));
      if (p == '0) begin tag = "R8"; return {1'b1, 2'b00, 3'b000}; end
      if (prim) begin tag = (r == 0) ? "R3" : "R1"; return {1'b1, 2'b00, 3'b000}; end
      if (!(m >= 3'd1 && m <= 3'd3)) begin tag = "R7"; return {1'b1, 2'b10, 3'b000}; end
      if (!inreg) begin tag = (p < b) ? "R2" : "R4"; return {1'b1, 2'b01, 3'b000}; end
      case (m)
         3'd1: begin tag = "R5"; return {1'b1, 2'b10, 3'b100}; end
         3'd2: begin tag = "R5"; return {1'b1, 2'b10, 3'b010}; end
         default: begin tag = "R6"; return {1'b1, 2'b10, 2'b00, (h != '0)}; end
      endcase
   endfunction

   task automatic run_one(input logic [W-1:0] p, b, r, rs, re, input logic [2:0] m,
                          input logic [W-1:0] h);
      string tag;
      logic [5:0] exp;
      obj_ptr = p; tgt_base = b; range_bytes = r; region_start = rs;
      region_end = re; mode = m; handler_cfg = h; req_valid = 1'b1;
      exp = model(p, b, r, rs, re, m, h, tag);
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      check(tag, {rsp_valid, rsp_result, fastfail_o, dbgbrk_o, handler_o}, exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      check("R9", {5'b0, req_ready}, 6'b0);
      check("R9", {rsp_valid, rsp_result, fastfail_o, dbgbrk_o, handler_o}, 6'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9", {5'b0, req_ready}, 6'b1);

      // sweeps: region start 32 -> window [64, 200]
      for (int bi = 0; bi < 2; bi++)
         for (int ri = 0; ri < 2; ri++)
            for (int m = 0; m < 8; m++)
               for (int hi = 0; hi < 2; hi++)
                  for (int p = 0; p < 256; p++)
                     run_one(W'(p), (bi == 0) ? W'(64) : W'(100), (ri == 0) ? W'(0) : W'(16),
                             W'(32), W'(200), 3'(m), (hi == 0) ? W'(0) : W'(16'h4000));

      // R2 large wrap: pointer just below base, big span still fails
      run_one(W'(99), W'(100), W'(16'h7fff), W'(32), W'(200), 3'd1, W'(1));

      // R9 back-to-back and pulse width
      obj_ptr = W'(70); tgt_base = W'(100); range_bytes = '0; region_start = W'(32);
      region_end = W'(200); mode = 3'd1; handler_cfg = '0; req_valid = 1'b1;
      @(negedge clk);
      obj_ptr = W'(100); mode = 3'd2;
      @(negedge clk);
      req_valid = 1'b0;
      check("R9", {rsp_valid, rsp_result, fastfail_o, dbgbrk_o, handler_o}, 6'b110100);
      @(negedge clk);
      check("R9", {rsp_valid, rsp_result, fastfail_o, dbgbrk_o, handler_o}, 6'b100000);
      @(negedge clk);
      check("R9", {rsp_valid, rsp_result, fastfail_o, dbgbrk_o, handler_o}, 6'b000000);

      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule